// File: doc/BRIEF.md
# Watchdog and Countdown Timer with Read-Cleared Flag

This block is an 8-bit down-counter that advances only on strobes from one of eight external tick sources, chosen by a 3-bit select field. A 2-bit mode field leaves it idle, runs it as a repeating countdown timer, or runs it as a one-shot watchdog. When the count runs out, the block raises a flag for the active mode and, if that flag's enable is set, drives an interrupt line. The interrupt is either a level that follows the flag or a one-cycle strobe at expiry.

Software reaches all configuration and status through a byte-wide register port with separate read and write strobes. The watchdog flag cannot be written. It clears as a side effect of reading the status byte. The countdown flag stays set until software writes a zero to it. A prescaler outside the block generates the tick strobes.

Top module: `cdwd_timer`

## Requirements
- R1: After a synchronous active-low reset, every register (0x01, 0x0F, 0x10 and 0x11) reads 0x00 and `irq` is low.
- R2: Mode field `ctrl[2:1]` at 0x0F works as follows: 01 is countdown, 10 is watchdog, and 00 or 11 is idle. In idle, ticks never cause an expiry.
- R3: Only the tick line indexed by the source field `src[2:0]` at 0x10 decrements the counter. Strobes on the other seven lines have no effect.
- R4: Two events load the counter from the reload value and restart the count: a write to the reload byte at 0x11, and a write that moves the mode from any other value into 01 or 10. Expiry then occurs on the N-th selected tick, where N is the reload value.
- R5: In watchdog mode, expiry sets status bit 7 at 0x01 and the counter stays at zero. No further expiry happens until the next load.
- R6: In countdown mode, expiry sets status bit 6. The counter reloads and expires again after another N ticks.
- R7: Status bit 7 ignores writes. A read of 0x01 returns the flag and clears it at that clock edge.
- R8: If a watchdog expiry and a read of 0x01 fall in the same cycle, the read returns the old value and the flag ends up set.
- R9: When `ctrl[7]` = 0, `irq` is a level equal to (bit 7 AND enable bit 2) OR (bit 6 AND enable bit 1) of the status byte.
- R10: When `ctrl[7]` = 1, `irq` is high for exactly the one cycle that follows an enabled expiry, and the flag stays set afterwards.
- R11: Writing 0 to status bit 6 clears the countdown flag. Writing 1 to it, or reading it, leaves it unchanged.
- R12: A reload value of zero never produces an expiry in either running mode.
- R13: Unused bits read as 0. Writing 0xFF to 0x0F reads back 0x86, and writing 0xFF to 0x10 reads back 0x07.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (a read of 0x01 clears the watchdog flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid while `reg_rd` is high, zero otherwise |
| tick_src | input | 8 | One strobe per source frequency, from the prescaler |
| irq | output | 1 | Interrupt, as a level or a strobe |

## Verification
The counter value is never visible at a port. A wrong internal count therefore shows up only as an expiry on the wrong tick: the flag or `irq` changes one selected tick early or late, in the cycle right after that tick's clock edge. A wrong load or restart condition shows the same way, and so does a counter that does not stop at zero. In each case the bench sees it on the expiry tick or on the first tick after it. Flag update faults, such as a lost set on a same-cycle read or a clear caused by a write, show on the very next read of 0x01 and, in level mode, on `irq` in the following cycle.

// File: rtl/cdwd_timer_pkg.sv
// Package: shared constants and types for the watchdog/countdown timer.
// Assumes byte-wide registers; the field positions below are decoded by
// software and must not move.
package cdwd_timer_pkg;

    // Register addresses
    localparam logic [7:0] ADR_STATUS = 8'h01;
    localparam logic [7:0] ADR_CTRL   = 8'h0F;
    localparam logic [7:0] ADR_SRC    = 8'h10;
    localparam logic [7:0] ADR_RELOAD = 8'h11;

    // Status byte bit positions
    localparam int ST_WDF = 7;  // watchdog flag, read-only, clear on read
    localparam int ST_CDF = 6;  // countdown flag, write 0 to clear
    localparam int ST_WDE = 2;  // watchdog interrupt enable
    localparam int ST_CDE = 1;  // countdown interrupt enable

    // Control byte bit positions
    localparam int CT_PULSE  = 7;  // 1 = pulsed interrupt
    localparam int CT_MODE_L = 1;  // mode field low bit (field is 2 bits)

    typedef enum logic [1:0] {
        MODE_IDLE  = 2'b00,
        MODE_COUNT = 2'b01,
        MODE_WDOG  = 2'b10,
        MODE_IDLE3 = 2'b11
    } tmr_mode_e;

endpackage

// File: rtl/cdwd_timer_regs.sv
// Module: register file and read mux for the timer.
// Holds the mode, pulse, source and reload fields and both interrupt enables.
// Produces the load strobe: a reload write, or a mode write that enters a
// running mode from a different mode. Assumes single-cycle read and write
// strobes that are never high in the same cycle.
module cdwd_timer_regs
    import cdwd_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wd_flag,
    input  logic              cd_flag,
    output logic [DATA_W-1:0] rdata,
    output tmr_mode_e         mode,
    output logic              pulse_mode,
    output logic [SRC_W-1:0]  src_sel,
    output logic [DATA_W-1:0] reload,
    output logic              wd_en,
    output logic              cd_en,
    output logic              load,
    output logic [DATA_W-1:0] load_val,
    output logic              rd_status,
    output logic              wr_status
);

    logic      sel_status, sel_ctrl, sel_src, sel_reload;
    tmr_mode_e new_mode;
    logic      new_running;

    // Address decode for the four registers
    always_comb begin
        sel_status = (addr == ADDR_W'(ADR_STATUS));
        sel_ctrl   = (addr == ADDR_W'(ADR_CTRL));
        sel_src    = (addr == ADDR_W'(ADR_SRC));
        sel_reload = (addr == ADDR_W'(ADR_RELOAD));
    end

    assign rd_status = rd && sel_status;
    assign wr_status = wr && sel_status;

    // Decode the mode carried by a control write and whether it runs the counter
    always_comb begin
        new_mode    = tmr_mode_e'(wdata[CT_MODE_L +: 2]);
        new_running = (new_mode == MODE_COUNT) || (new_mode == MODE_WDOG);
    end

    // Load strobe and value: a reload write takes the fresh data
    always_comb begin
        load     = 1'b0;
        load_val = reload;
        if (wr && sel_reload) begin
            load     = 1'b1;
            load_val = wdata;
        end else if (wr && sel_ctrl && new_running && (new_mode != mode)) begin
            load = 1'b1;
        end
    end

    // Control register: mode and interrupt style
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode       <= MODE_IDLE;
            pulse_mode <= 1'b0;
        end else if (wr && sel_ctrl) begin
            mode       <= new_mode;
            pulse_mode <= wdata[CT_PULSE];
        end
    end

    // Source select register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel <= '0;
        end else if (wr && sel_src) begin
            src_sel <= wdata[SRC_W-1:0];
        end
    end

    // Reload register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload <= '0;
        end else if (wr && sel_reload) begin
            reload <= wdata;
        end
    end

    // Interrupt enables in the status byte (the flags live elsewhere)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_en <= 1'b0;
            cd_en <= 1'b0;
        end else if (wr_status) begin
            wd_en <= wdata[ST_WDE];
            cd_en <= wdata[ST_CDE];
        end
    end

    // Read mux; unused bits return zero
    always_comb begin
        rdata = '0;
        if (rd) begin
            if (sel_status) begin
                rdata[ST_WDF] = wd_flag;
                rdata[ST_CDF] = cd_flag;
                rdata[ST_WDE] = wd_en;
                rdata[ST_CDE] = cd_en;
            end else if (sel_ctrl) begin
                rdata[CT_PULSE]       = pulse_mode;
                rdata[CT_MODE_L +: 2] = mode;
            end else if (sel_src) begin
                rdata[SRC_W-1:0] = src_sel;
            end else if (sel_reload) begin
                rdata = reload;
            end
        end
    end

endmodule

// File: rtl/cdwd_timer_count.sv
// Module: tick source select and down-counter.
// Decrements on the selected tick strobe. An expiry is the tick that moves
// the count from one to zero. Countdown mode then reloads; watchdog mode
// holds at zero. A load has priority over a tick in the same cycle.
module cdwd_timer_count
    import cdwd_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int SRC_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [(1<<SRC_W)-1:0] tick_src,
    input  logic [SRC_W-1:0]      src_sel,
    input  tmr_mode_e             mode,
    input  logic [DATA_W-1:0]     reload,
    input  logic                  load,
    input  logic [DATA_W-1:0]     load_val,
    output logic [DATA_W-1:0]     count,
    output logic                  wd_exp,
    output logic                  cd_exp
);

    localparam int              NUM_SRC = 1 << SRC_W;
    localparam logic [DATA_W-1:0] ONE   = DATA_W'(1);

    logic [NUM_SRC-1:0] hit;
    logic               tick_sel;
    logic               running;
    logic               expire;

    // One-hot match of each tick line against the source select
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign hit[i] = tick_src[i] && (src_sel == SRC_W'(i));
    end

    assign tick_sel = |hit;

    // Expiry detect for the active mode
    always_comb begin
        running = (mode == MODE_COUNT) || (mode == MODE_WDOG);
        expire  = running && tick_sel && !load && (count == ONE);
        wd_exp  = expire && (mode == MODE_WDOG);
        cd_exp  = expire && (mode == MODE_COUNT);
    end

    // Counter: load, then decrement or reload on selected ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (running && tick_sel && (count != '0)) begin
            if (cd_exp) begin
                count <= reload;
            end else begin
                count <= count - ONE;
            end
        end
    end

endmodule

// File: rtl/cdwd_timer_irq.sv
// Module: expiry flags and the interrupt output.
// The watchdog flag is set by an expiry and cleared by a status read, with
// the set winning a tie. The countdown flag is cleared by writing 0 to its bit.
// The interrupt is a level (flag AND enable) or a registered one-cycle strobe.
module cdwd_timer_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_exp,
    input  logic cd_exp,
    input  logic rd_status,
    input  logic wr_status,
    input  logic wr_cdf_bit,
    input  logic wd_en,
    input  logic cd_en,
    input  logic pulse_mode,
    output logic wd_flag,
    output logic cd_flag,
    output logic irq
);

    logic strobe_q;

    // Watchdog flag: set on expiry, cleared by a status read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wd_flag <= 1'b0;
        end else if (wd_exp) begin
            wd_flag <= 1'b1;
        end else if (rd_status) begin
            wd_flag <= 1'b0;
        end
    end

    // Countdown flag: set on expiry, cleared by writing zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cd_flag <= 1'b0;
        end else if (cd_exp) begin
            cd_flag <= 1'b1;
        end else if (wr_status && !wr_cdf_bit) begin
            cd_flag <= 1'b0;
        end
    end

    // One-cycle strobe after an enabled expiry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= (wd_exp && wd_en) || (cd_exp && cd_en);
        end
    end

    // Output select between strobe and level
    always_comb begin
        if (pulse_mode) begin
            irq = strobe_q;
        end else begin
            irq = (wd_flag && wd_en) || (cd_flag && cd_en);
        end
    end

endmodule

// File: rtl/cdwd_timer.sv
// Module: top of the watchdog/countdown timer.
// Connects the register file, the counter and the flag/interrupt logic.
// Assumes the tick strobes are one clock wide and synchronous to clk.
module cdwd_timer
    import cdwd_timer_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic                  reg_wr,
    input  logic                  reg_rd,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [(1<<SRC_W)-1:0] tick_src,
    output logic                  irq
);

    tmr_mode_e         mode_w;
    logic              pulse_w;
    logic [SRC_W-1:0]  src_w;
    logic [DATA_W-1:0] reload_w;
    logic              wd_en_w, cd_en_w;
    logic              load_w;
    logic [DATA_W-1:0] load_val_w;
    logic              rd_status_w, wr_status_w;
    logic [DATA_W-1:0] count_w;
    logic              wd_exp_w, cd_exp_w;
    logic              wd_flag_w, cd_flag_w;

    cdwd_timer_regs #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .SRC_W  (SRC_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr       (reg_addr),
        .wr         (reg_wr),
        .rd         (reg_rd),
        .wdata      (reg_wdata),
        .wd_flag    (wd_flag_w),
        .cd_flag    (cd_flag_w),
        .rdata      (reg_rdata),
        .mode       (mode_w),
        .pulse_mode (pulse_w),
        .src_sel    (src_w),
        .reload     (reload_w),
        .wd_en      (wd_en_w),
        .cd_en      (cd_en_w),
        .load       (load_w),
        .load_val   (load_val_w),
        .rd_status  (rd_status_w),
        .wr_status  (wr_status_w)
    );

    cdwd_timer_count #(
        .DATA_W (DATA_W),
        .SRC_W  (SRC_W)
    ) count_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_src (tick_src),
        .src_sel  (src_w),
        .mode     (mode_w),
        .reload   (reload_w),
        .load     (load_w),
        .load_val (load_val_w),
        .count    (count_w),
        .wd_exp   (wd_exp_w),
        .cd_exp   (cd_exp_w)
    );

    cdwd_timer_irq irq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_exp     (wd_exp_w),
        .cd_exp     (cd_exp_w),
        .rd_status  (rd_status_w),
        .wr_status  (wr_status_w),
        .wr_cdf_bit (reg_wdata[ST_CDF]),
        .wd_en      (wd_en_w),
        .cd_en      (cd_en_w),
        .pulse_mode (pulse_w),
        .wd_flag    (wd_flag_w),
        .cd_flag    (cd_flag_w),
        .irq        (irq)
    );

endmodule

// File: rtl/cdwd_timer_chk.sv
// Module: property checker for the timer, attached to the top by bind.
// Observes mode, count, load, expiry, flag and interrupt signals.
module cdwd_timer_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode,
    input logic              pulse_mode,
    input logic [DATA_W-1:0] count,
    input logic              load,
    input logic              wd_exp,
    input logic              cd_exp,
    input logic              rd_status,
    input logic              wd_flag,
    input logic              irq
);

    logic running;
    assign running = (mode == 2'b01) || (mode == 2'b10);

    // R2: an idle counter only changes on a load
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !load) |=> $stable(count));

    // R5: a watchdog counter at zero stays there until loaded
    assert_wdog_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && count == '0 && !load) |=> (count == '0));

    // R7: a status read without a coincident expiry clears the flag
    assert_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !wd_exp) |=> !wd_flag);

    // R8: an expiry always leaves the flag set, even with a read
    assert_expiry_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wd_exp |=> wd_flag);

    // R10: in pulsed mode a high interrupt follows an expiry
    assert_pulse_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_mode && $past(pulse_mode) && irq) |-> $past(wd_exp || cd_exp));

endmodule

bind cdwd_timer cdwd_timer_chk #(.DATA_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_w),
    .pulse_mode (pulse_w),
    .count      (count_w),
    .load       (load_w),
    .wd_exp     (wd_exp_w),
    .cd_exp     (cd_exp_w),
    .rd_status  (rd_status_w),
    .wd_flag    (wd_flag_w),
    .irq        (irq)
);

// File: tb/cdwd_timer_tb.sv
// Bench for cdwd_timer: vector table of watchdog runs, then directed tests.
module cdwd_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] tick_src = '0;
    logic       irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10ns clk = ~clk;

    cdwd_timer dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .tick_src  (tick_src),
        .irq       (irq)
    );

    // Vector: {source, reload, expected tick count to expiry}
    localparam logic [18:0] VEC [0:4] = '{
        {3'd2, 8'd3,   8'd3},
        {3'd0, 8'd1,   8'd1},
        {3'd5, 8'd7,   8'd7},
        {3'd7, 8'd20,  8'd20},
        {3'd1, 8'd255, 8'd255}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1ns;
        d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic tick(input int idx);
        @(negedge clk);
        tick_src = 8'(1 << idx);
        @(negedge clk);
        tick_src = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        logic [7:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        #4ms;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd_chk("R1 status", 8'h01, 8'h00);
        rd_chk("R1 ctrl", 8'h0F, 8'h00);
        rd_chk("R1 src", 8'h10, 8'h00);
        rd_chk("R1 reload", 8'h11, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R13: field layout, unused bits read zero
        wr(8'h0F, 8'hFF); rd_chk("R13 ctrl", 8'h0F, 8'h86);
        wr(8'h10, 8'hFF); rd_chk("R13 src", 8'h10, 8'h07);
        wr(8'h0F, 8'h00);

        // Vector table: watchdog expiry on the N-th selected tick
        for (int i = 0; i < 5; i++) begin
            logic [2:0] s;
            logic [7:0] rl, n;
            {s, rl, n} = VEC[i];
            wr(8'h0F, 8'h00);
            wr(8'h01, 8'h04);
            wr(8'h10, {5'd0, s});
            wr(8'h11, rl);
            wr(8'h0F, 8'h04);
            for (int k = 1; k < int'(n); k++) begin
                tick((int'(s) + 1) % 8);
                tick(int'(s));
            end
            chk("R3 R4 no early expiry", {7'd0, irq}, 8'h00);
            tick(int'(s));
            chk("R4 expiry on Nth tick", {7'd0, irq}, 8'h01);
            rd_chk("R5 wd flag set", 8'h01, 8'h84);
            tick(int'(s)); tick(int'(s));
            chk("R5 wd holds at zero", {7'd0, irq}, 8'h00);
        end

        // R2: modes 11 and 00 are idle
        wr(8'h0F, 8'h00); wr(8'h01, 8'h00); wr(8'h10, 8'h00);
        wr(8'h0F, 8'h06); wr(8'h11, 8'h01);
        tick(0); tick(0);
        rd_chk("R2 mode 11 idle", 8'h01, 8'h00);
        wr(8'h0F, 8'h00); tick(0);
        rd_chk("R2 mode 00 idle", 8'h01, 8'h00);
        wr(8'h0F, 8'h02); tick(0);
        rd_chk("R2 mode 01 counts", 8'h01, 8'h40);
        wr(8'h01, 8'h00);

        // R6/R9/R11: countdown repeats, level irq, write-zero clear
        wr(8'h0F, 8'h00); wr(8'h11, 8'h02); wr(8'h01, 8'h02); wr(8'h0F, 8'h02);
        tick(0);
        chk("R6 not yet", {7'd0, irq}, 8'h00);
        tick(0);
        chk("R9 level irq", {7'd0, irq}, 8'h01);
        rd_chk("R6 cd flag", 8'h01, 8'h42);
        rd_chk("R11 read keeps cd flag", 8'h01, 8'h42);
        wr(8'h01, 8'h42);
        rd_chk("R11 write one keeps flag", 8'h01, 8'h42);
        wr(8'h01, 8'h02);
        chk("R11 cleared irq", {7'd0, irq}, 8'h00);
        rd_chk("R11 write zero clears", 8'h01, 8'h02);
        tick(0);
        chk("R6 reload half", {7'd0, irq}, 8'h00);
        tick(0);
        chk("R6 second expiry", {7'd0, irq}, 8'h01);
        wr(8'h01, 8'h00);

        // R7/R9: wd flag read-only, enable gating of level irq
        wr(8'h0F, 8'h00); wr(8'h11, 8'h02);
        wr(8'h01, 8'h80);
        rd_chk("R7 write ignored", 8'h01, 8'h00);
        wr(8'h0F, 8'h04);
        tick(0); tick(0);
        chk("R9 disabled no irq", {7'd0, irq}, 8'h00);
        wr(8'h01, 8'h04);
        chk("R9 enable raises irq", {7'd0, irq}, 8'h01);
        wr(8'h01, 8'h04);
        chk("R7 write does not clear", {7'd0, irq}, 8'h01);
        rd_chk("R7 read returns flag", 8'h01, 8'h84);
        chk("R7 read cleared irq", {7'd0, irq}, 8'h00);
        rd_chk("R7 flag clear", 8'h01, 8'h04);

        // R8: expiry and status read in the same cycle
        wr(8'h0F, 8'h00); wr(8'h11, 8'h01); wr(8'h0F, 8'h04);
        @(negedge clk);
        tick_src = 8'h01; reg_addr = 8'h01; reg_rd = 1'b1;
        #1ns;
        v = reg_rdata;
        @(negedge clk);
        tick_src = '0; reg_rd = 1'b0;
        chk("R8 read sees old", v, 8'h04);
        rd_chk("R8 flag survives", 8'h01, 8'h84);
        rd_chk("R8 then clears", 8'h01, 8'h04);

        // R10: pulsed interrupt
        wr(8'h0F, 8'h00); wr(8'h11, 8'h02); wr(8'h0F, 8'h84);
        tick(0);
        chk("R10 before expiry", {7'd0, irq}, 8'h00);
        tick(0);
        chk("R10 strobe high", {7'd0, irq}, 8'h01);
        @(negedge clk);
        chk("R10 strobe one cycle", {7'd0, irq}, 8'h00);
        rd_chk("R10 flag stays", 8'h01, 8'h84);

        // R4: reload write restarts the count
        wr(8'h0F, 8'h00); wr(8'h11, 8'h03); wr(8'h0F, 8'h04);
        tick(0); tick(0);
        wr(8'h11, 8'h03);
        tick(0); tick(0);
        rd_chk("R4 restart delays", 8'h01, 8'h04);
        tick(0);
        rd_chk("R4 expiry after restart", 8'h01, 8'h84);

        // R12: reload zero never expires
        wr(8'h0F, 8'h00); wr(8'h11, 8'h00); wr(8'h01, 8'h02); wr(8'h0F, 8'h02);
        for (int k = 0; k < 5; k++) tick(0);
        rd_chk("R12 no expiry", 8'h01, 8'h02);
        chk("R12 irq low", {7'd0, irq}, 8'h00);

        // R1: reset mid-run
        wr(8'h11, 8'h01); wr(8'h0F, 8'h00); wr(8'h0F, 8'h02); tick(0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R1 status after reset", 8'h01, 8'h00);
        rd_chk("R1 reload after reset", 8'h11, 8'h00);
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule